// File: doc/BRIEF.md
# Priority Bus Arbiter with Burst Preemption

This block arbitrates a shared bus among a parameterized set of masters, up to sixteen. Each master raises a request together with a two-bit urgency level. The arbiter grants the bus to a requester at the highest level present. When several requesters share that level, a configuration input chooses the tie-break. One setting always favours the lowest index. The other rotates among the tied masters.

A master that holds the bus in the middle of a burst keeps its grant until a burst budget runs out. The budget is loaded from a programmable count when the grant is issued and counts down on each held cycle. Once it reaches zero and some other master waits at a strictly higher level, the owner loses the grant on the next edge. A locked owner is never preempted. A master that is neither bursting nor locked is arbitrated again on every cycle. The grant output is registered and one-hot. Address decode and data steering belong to neighbouring blocks.

Top module: `prio_bus_arbiter`

## Requirements
- R1: `grant` is always one-hot or zero, and a synchronous reset drives it to zero.
- R2: When no master requests, `grant` is zero on the cycle after that edge.
- R3: Master i's level sits at `prio[2i+1:2i]`, and 3 is the most urgent. A new grant always goes to a requester at the highest level present.
- R4: With `rr_mode` = 0, ties at the top level go to the lowest-indexed tied master.
- R5: With `rr_mode` = 1, the winner is the first tied master found from the rotation pointer upward, wrapping around. After each such grant the pointer moves to the winner's index plus one, modulo the master count. Reset sets the pointer to 0, and a grant in fixed mode leaves it unchanged.
- R6: An owner that keeps `req` and `burst_act` high keeps its grant while its budget counter is nonzero, even when a higher level waits.
- R7: The budget counter is loaded with `burst_limit` on each new grant and decrements on each held cycle. When it is zero and another master requests at a strictly higher level, the grant moves at the next edge. A waiting master at an equal or lower level does not preempt.
- R8: An owner with `lock` high keeps its grant whatever the counter and the other levels are.
- R9: An owner that is neither bursting nor locked is arbitrated again on every cycle, as if it were one requester among the others.
- R10: An owner that drops `req` loses the grant at the next edge.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| req | input | N_MST | Per-master request |
| prio | input | 2*N_MST | Per-master two-bit level, master i at bits [2i+1:2i] |
| lock | input | N_MST | Per-master atomic-sequence hold |
| burst_act | input | N_MST | Per-master burst in progress |
| rr_mode | input | 1 | 0 = fixed-order tie-break, 1 = rotating tie-break |
| burst_limit | input | TMR_W | Held cycles granted to a burst before it may be preempted |
| grant | output | N_MST | Registered one-hot grant |

## Verification
The bench goes after the exact cycle when preemption happens. An arbiter that checks the counter one cycle early or late moves the grant on the wrong vector. One that preempts for an equal-level waiter drops an owner that must stay. The rotating tie-break is walked through a full wrap and a sparse request pattern. A pointer that advances in fixed mode, or that steps by one instead of jumping past the winner, picks the wrong master. Lock with an expired counter and a higher waiter catches a design that lets preemption override the lock. Reset during an active grant, followed by a rotating arbitration, catches a pointer that survives reset.

// File: rtl/arb_pkg.sv
package arb_pkg;
  localparam int LVL_W = 2;
  typedef logic [LVL_W-1:0] lvl_t;
endpackage

// File: rtl/arb_level_select.sv
module arb_level_select
  import arb_pkg::*;
#(
  parameter int N_MST = 8
) (
  input  logic [N_MST-1:0]       req,
  input  logic [LVL_W*N_MST-1:0] prio,
  output lvl_t                   top_lvl,
  output logic [N_MST-1:0]       cand
);
  always_comb begin
    top_lvl = '0;
    for (int i = 0; i < N_MST; i++) begin
      if (req[i] && (prio[i*LVL_W +: LVL_W] > top_lvl))
        top_lvl = prio[i*LVL_W +: LVL_W];
    end
  end

  for (genvar g = 0; g < N_MST; g++) begin : g_cand
    assign cand[g] = req[g] && (prio[g*LVL_W +: LVL_W] == top_lvl);
  end
endmodule

// File: rtl/arb_pick.sv
module arb_pick #(
  parameter int N_MST = 8,
  localparam int IW = (N_MST > 1) ? $clog2(N_MST) : 1
) (
  input  logic [N_MST-1:0] cand,
  input  logic [IW-1:0]    start,
  output logic             found,
  output logic [IW-1:0]    win_idx,
  output logic [N_MST-1:0] win_oh
);
  always_comb begin
    found   = 1'b0;
    win_idx = '0;
    for (int k = 0; k < N_MST; k++) begin
      int j;
      j = (int'(start) + k) % N_MST;
      if (!found && cand[j]) begin
        found   = 1'b1;
        win_idx = IW'(j);
      end
    end
    win_oh = '0;
    if (found) win_oh[win_idx] = 1'b1;
  end
endmodule

// File: rtl/arb_burst_timer.sv
module arb_burst_timer #(
  parameter int TMR_W = 8
) (
  input  logic             clk,
  input  logic             rst,
  input  logic             load,
  input  logic             tick,
  input  logic [TMR_W-1:0] limit,
  output logic             expired
);
  logic [TMR_W-1:0] cnt;

  always_ff @(posedge clk) begin
    if (rst)                   cnt <= '0;
    else if (load)             cnt <= limit;
    else if (tick && cnt != 0) cnt <= cnt - 1'b1;
  end

  assign expired = (cnt == '0);

  // R7: without a load the budget never grows
  assert_budget_no_grow_R7: assert property (@(posedge clk) disable iff (rst)
    !$past(load) && !$past(rst) |-> cnt <= $past(cnt));
endmodule

// File: rtl/prio_bus_arbiter.sv
module prio_bus_arbiter
  import arb_pkg::*;
#(
  parameter int N_MST = 8,
  parameter int TMR_W = 8,
  localparam int IW = (N_MST > 1) ? $clog2(N_MST) : 1
) (
  input  logic                   clk,
  input  logic                   rst,
  input  logic [N_MST-1:0]       req,
  input  logic [LVL_W*N_MST-1:0] prio,
  input  logic [N_MST-1:0]       lock,
  input  logic [N_MST-1:0]       burst_act,
  input  logic                   rr_mode,
  input  logic [TMR_W-1:0]       burst_limit,
  output logic [N_MST-1:0]       grant
);
  logic [N_MST-1:0] grant_q;
  logic [IW-1:0]    owner_q;
  logic [IW-1:0]    rr_ptr_q;
  lvl_t             top_lvl;
  logic [N_MST-1:0] cand;
  logic             found;
  logic [IW-1:0]    win_idx;
  logic [N_MST-1:0] win_oh;
  logic             expired;
  logic             owned, higher_wait, preempt, hold;
  lvl_t             owner_lvl;

  arb_level_select #(.N_MST(N_MST)) u_lvl (
    .req(req), .prio(prio), .top_lvl(top_lvl), .cand(cand));

  arb_pick #(.N_MST(N_MST)) u_pick (
    .cand(cand), .start(rr_mode ? rr_ptr_q : '0),
    .found(found), .win_idx(win_idx), .win_oh(win_oh));

  assign owned     = |grant_q;
  assign owner_lvl = prio[owner_q*LVL_W +: LVL_W];

  always_comb begin
    higher_wait = 1'b0;
    for (int i = 0; i < N_MST; i++) begin
      if (req[i] && (IW'(i) != owner_q) && (prio[i*LVL_W +: LVL_W] > owner_lvl))
        higher_wait = 1'b1;
    end
  end

  assign preempt = expired && higher_wait;
  assign hold    = owned && req[owner_q] &&
                   (lock[owner_q] || (burst_act[owner_q] && !preempt));

  arb_burst_timer #(.TMR_W(TMR_W)) u_tmr (
    .clk(clk), .rst(rst), .load(!hold && found), .tick(hold),
    .limit(burst_limit), .expired(expired));

  always_ff @(posedge clk) begin
    if (rst) begin
      grant_q  <= '0;
      owner_q  <= '0;
      rr_ptr_q <= '0;
    end else if (!hold) begin
      grant_q <= win_oh;
      if (found) begin
        owner_q <= win_idx;
        if (rr_mode)
          rr_ptr_q <= (win_idx == IW'(N_MST-1)) ? '0 : win_idx + 1'b1;
      end
    end
  end

  assign grant = grant_q;

  // R1: at most one owner
  assert_grant_onehot_R1: assert property (@(posedge clk) disable iff (rst)
    $onehot0(grant));
  // R2: idle bus releases the grant
  assert_idle_release_R2: assert property (@(posedge clk) disable iff (rst)
    req == '0 |=> grant == '0);
  // R10: grant only to a master that requested on the previous cycle
  assert_grant_requested_R10: assert property (@(posedge clk) disable iff (rst)
    (grant & ~$past(req)) == '0);
  // R8: a locked requesting owner keeps the bus
  assert_lock_keeps_R8: assert property (@(posedge clk) disable iff (rst)
    (|(grant & req & lock)) |=> grant == $past(grant));
  // R3: any requester leaves a top-level candidate
  assert_cand_present_R3: assert property (@(posedge clk) disable iff (rst)
    (req != '0) |-> (cand != '0));
endmodule

// File: tb/prio_bus_arbiter_bench.sv
module prio_bus_arbiter_bench;
  localparam int N = 4;
  localparam int TW = 4;

  logic clk = 1'b0;
  logic rst = 1'b1;
  logic [N-1:0]   req = '0, lock = '0, burst_act = '0, grant;
  logic [2*N-1:0] prio = '0;
  logic           rr_mode = 1'b0;
  logic [TW-1:0]  burst_limit = 4'd2;

  int checks = 0;
  int errors = 0;
  bit done = 1'b0;

  always #5 clk = ~clk;

  prio_bus_arbiter #(.N_MST(N), .TMR_W(TW)) u_prio_bus_arbiter (
    .clk(clk), .rst(rst), .req(req), .prio(prio), .lock(lock),
    .burst_act(burst_act), .rr_mode(rr_mode), .burst_limit(burst_limit),
    .grant(grant));

  // vector: {req, prio, lock, burst, rr_mode, expected grant}
  localparam int NV = 21;
  localparam logic [24:0] VEC [NV] = '{
    {4'h0, 8'h00, 4'h0, 4'h0, 1'b0, 4'h0},  // R2 idle
    {4'hF, 8'h55, 4'h0, 4'h0, 1'b0, 4'h1},  // R4 fixed low index
    {4'hF, 8'h75, 4'h0, 4'h0, 1'b0, 4'h4},  // R3 R9 higher level wins
    {4'hF, 8'h55, 4'h0, 4'h0, 1'b1, 4'h1},  // R5 pointer still 0
    {4'hF, 8'h55, 4'h0, 4'h0, 1'b1, 4'h2},  // R5
    {4'hF, 8'h55, 4'h0, 4'h0, 1'b1, 4'h4},  // R5
    {4'hF, 8'h55, 4'h0, 4'h0, 1'b1, 4'h8},  // R5 wrap next
    {4'hA, 8'h55, 4'h0, 4'h0, 1'b1, 4'h2},  // R5 sparse from 0
    {4'hA, 8'h55, 4'h0, 4'h0, 1'b1, 4'h8},  // R5 skip to 3
    {4'h0, 8'h00, 4'h0, 4'h0, 1'b0, 4'h0},  // R2
    {4'h1, 8'h00, 4'h0, 4'h1, 1'b0, 4'h1},  // R7 load budget
    {4'h3, 8'h0C, 4'h0, 4'h1, 1'b0, 4'h1},  // R6 budget 2
    {4'h3, 8'h0C, 4'h0, 4'h1, 1'b0, 4'h1},  // R6 budget 1
    {4'h3, 8'h0C, 4'h0, 4'h1, 1'b0, 4'h2},  // R7 preempted
    {4'h3, 8'h00, 4'h0, 4'h2, 1'b0, 4'h2},  // R6
    {4'h3, 8'h00, 4'h0, 4'h2, 1'b0, 4'h2},  // R6
    {4'h3, 8'h00, 4'h0, 4'h2, 1'b0, 4'h2},  // R7 equal level no preempt
    {4'h3, 8'h03, 4'h2, 4'h2, 1'b0, 4'h2},  // R8 lock beats preempt
    {4'h3, 8'h03, 4'h0, 4'h2, 1'b0, 4'h1},  // R7 lock gone, preempt
    {4'h2, 8'h00, 4'h0, 4'h0, 1'b0, 4'h2},  // R10 owner dropped
    {4'h0, 8'h00, 4'h0, 4'h0, 1'b0, 4'h0}   // R2
  };
  localparam int TAG [NV] = '{2,4,3,5,5,5,5,5,5,2,7,6,6,7,6,6,7,8,7,10,2};

  task automatic check(input logic [N-1:0] exp, input int rq);
    checks++;
    if (grant !== exp) begin
      errors++;
      $display("FAIL R%0d grant actual %b expected %b", rq, grant, exp);
    end
  endtask

  task automatic onehot_check();
    checks++;
    if (!$onehot0(grant)) begin
      errors++;
      $display("FAIL R1 grant actual %b expected one-hot or zero", grant);
    end
  endtask

  task automatic step();
    @(posedge clk);
    #1;
  endtask

  initial begin
    int cyc = 0;
    while (!done) begin
      @(posedge clk);
      cyc++;
      if (cyc > 5000) begin
        errors++;
        $display("FAIL watchdog actual %0d expected below 5000 cycles", cyc);
        $display("CHECKS %0d ERRORS %0d", checks, errors);
        $finish;
      end
    end
  end

  initial begin
    step(); step();
    check('0, 1);  // R1 reset state
    @(negedge clk) rst = 1'b0;
    for (int v = 0; v < NV; v++) begin
      @(negedge clk);
      {req, prio, lock, burst_act, rr_mode} = VEC[v][24:4];
      step();
      check(VEC[v][3:0], TAG[v]);
      onehot_check();  // R1
    end
    // R5: advance pointer, then reset must return it to 0
    @(negedge clk);
    req = 4'hF; prio = 8'h55; rr_mode = 1'b1; lock = '0; burst_act = '0;
    step(); check(4'h1, 5);
    step(); check(4'h2, 5);
    @(negedge clk) rst = 1'b1;
    step(); check('0, 1);  // R1 reset clears active grant
    @(negedge clk) rst = 1'b0;
    step(); check(4'h1, 5);  // R5 pointer back at 0
    done = 1'b1;
    $display("CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end
endmodule